// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer Core

This block is a parameterised counter (32 bits by default) that moves by one each time the count-tick input pulses for a single cycle, provided the control word has both its enable and its run bit set. It counts upward with wrap, downward with wrap, or up and down in a triangle between zero and all-ones. In each direction it can run freely, stop once it reaches a terminal value or the match value, or load a value from a bank of four reload registers and keep counting.

Software reaches the control word, the match register and the reload bank through one write port with a small address. The reload entry to be used comes from a two-bit pointer. A clear bit in the control word sets that pointer, and the pointer can step up or down, wrapping, after each reload. The outputs are the count, a one-cycle event pulse, one trigger pulse on a selected line, the pointer value, and a read-back of the control word. When a single-shot mode completes, the read-back shows the run bit cleared.

Top module: `updn_timer`

## Requirements
- R1: After synchronous reset the count, event, triggers, reload pointer and control read-back are all zero.
- R2: The count changes only in a cycle where `tick_i` is 1, control bit 0 (enable) is 1 and control bit 1 (run) is 1. Otherwise it holds.
- R3: Control bits [4:3] pick the direction. 0 counts up by one and wraps from all-ones to zero. 1 counts down by one and wraps from zero to all-ones.
- R4: Direction 2 is a triangle. The count rises to all-ones and then falls to zero, reversing on the step that arrives at either extreme, so no extreme value appears twice in a row.
- R5: Control bits [7:5] pick the mode. In mode 0 the count runs freely, and `evt_o` pulses in the cycle in which the count shows the value equal to the match register (address 1).
- R6: Mode 1 stops when the count reaches its terminal value: all-ones when counting up, zero when counting down, either extreme in the triangle. `evt_o` pulses, control bit 1 reads back 0, and the count then holds.
- R7: Mode 2 stops in the same way when the count reaches the match value.
- R8: In mode 3, the step that would reach the terminal value loads the reload entry selected by the pointer instead, pulses `evt_o`, and counting continues.
- R9: Mode 4 does the same as mode 3 when the step would reach the match value.
- R10: Control bits [11:10] set the pointer step applied after each reload: 0 keeps the pointer, 1 adds one, 2 subtracts one. Both steps wrap modulo 4.
- R11: Writing control bit 2 as 1 sets the count to 0 and loads the pointer from control bits [9:8]. This takes priority over counting in that cycle. Bit 2 always reads back 0.
- R12: Control bits [13:12] route the event. 0 drives no trigger. A value k from 1 to 3 pulses `trig_o[k-1]` together with `evt_o`.
- R13: Write addresses: 0 is the control word, 1 is the match register, 4 to 7 are reload entries 0 to 3. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle count-enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| count_o | output | 32 | Current count |
| evt_o | output | 1 | Match or terminal event pulse |
| trig_o | output | 3 | Routed trigger pulses |
| rld_idx_o | output | 2 | Active reload pointer |
| ctrl_o | output | 32 | Control word read-back |

## Verification
The bench runs a behavioural model alongside the block and compares every output on every clock. It aims at the triangle's turning points: a design that flips one step late shows all-ones or zero twice. It also targets the wrap-around of the reload pointer in both directions, where a wrong modulo would select a bank entry that was never written. A single-shot stop that leaves the run bit set would keep counting past the terminal or match value, and a reload taken one step late would expose the terminal value on `count_o`. Both would show as mismatches. Trigger routing is checked for each selector value, and so are writes to unused addresses, which must leave the match behaviour unchanged.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    localparam int RLD_N  = 4;
    localparam int RLD_IW = $clog2(RLD_N);
    localparam int TRIG_N = 3;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        DR_UP   = 2'd0,
        DR_DOWN = 2'd1,
        DR_TRI  = 2'd2
    } dir_e;

    typedef enum logic [2:0] {
        MD_FREE      = 3'd0,
        MD_ONE_TERM  = 3'd1,
        MD_ONE_MATCH = 3'd2,
        MD_RLD_TERM  = 3'd3,
        MD_RLD_MATCH = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_KEEP = 2'd0,
        ST_INC  = 2'd1,
        ST_DEC  = 2'd2
    } step_e;

    // control word, bit 0 at the bottom of the struct
    typedef struct packed {
        logic [1:0]        trig;
        logic [1:0]        step;
        logic [RLD_IW-1:0] rsel;
        logic [2:0]        mode;
        logic [1:0]        dir;
        logic              clr;
        logic              start;
        logic              en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MATCH = 3'd1;

    function automatic logic is_rld_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic logic [RLD_IW-1:0] ptr_next(input logic [RLD_IW-1:0] cur,
                                                   input logic [1:0] stp);
        logic [RLD_IW-1:0] r;
        case (stp)
            ST_INC:  r = cur + RLD_IW'(1);
            ST_DEC:  r = cur - RLD_IW'(1);
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/updn_tmr_regs.sv
module updn_tmr_regs
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NRLD  = RLD_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic                    stop_req,
    input  logic [$clog2(NRLD)-1:0] rd_idx,
    output ctrl_t                   ctrl_q,
    output logic                    clr_pulse,
    output logic [$clog2(NRLD)-1:0] clr_idx,
    output logic [CNT_W-1:0]        match_q,
    output logic [CNT_W-1:0]        reload_val
);
    localparam int IW = $clog2(NRLD);

    ctrl_t              wr_ctrl;
    logic               ctrl_wr;
    logic [CNT_W-1:0]   bank [NRLD];

    assign wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign clr_pulse = ctrl_wr && wr_ctrl.clr;
    assign clr_idx   = wr_ctrl.rsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q     <= wr_ctrl;
            ctrl_q.clr <= 1'b0;
        end else if (stop_req) begin
            ctrl_q.start <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            match_q <= '0;
        else if (wr_en && (wr_addr == A_MATCH))
            match_q <= wr_data;
    end

    for (genvar g = 0; g < NRLD; g++) begin : g_rld
        logic [CNT_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && is_rld_addr(wr_addr) && (wr_addr[IW-1:0] == IW'(g)))
                q <= wr_data;
        end
        assign bank[g] = q;
    end

    assign reload_val = bank[rd_idx];

    // R6 / R7: a single-shot stop clears the run bit unless software rewrites it
    p_stop_clears_run_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !ctrl_wr) |=> !ctrl_q.start);

    // R11: clear bit never sticks in the stored word
    p_clr_selfclear_r11: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> (ctrl_q.clr == 1'b0) && (ctrl_q.rsel == $past(clr_idx)));

endmodule

// File: rtl/updn_tmr_step.sv
module updn_tmr_step
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  ctrl_t            ctrl,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tri_down,
    input  logic [CNT_W-1:0] match,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             nxt_tri,
    output logic             evt,
    output logic             stop_req,
    output logic             rld_take
);
    localparam logic [CNT_W-1:0] CMAX  = '1;
    localparam logic [CNT_W-1:0] CZERO = '0;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic             going_down;
    logic [CNT_W-1:0] raw;
    logic             at_term;
    logic             at_match;

    always_comb begin
        case (ctrl.dir)
            DR_DOWN: going_down = 1'b1;
            DR_TRI:  going_down = tri_down ? (cnt != CZERO) : (cnt == CMAX);
            default: going_down = 1'b0;
        endcase

        raw = going_down ? (cnt - ONE) : (cnt + ONE);

        case (ctrl.dir)
            DR_DOWN: at_term = (raw == CZERO);
            DR_TRI:  at_term = (raw == CZERO) || (raw == CMAX);
            default: at_term = (raw == CMAX);
        endcase

        at_match = (raw == match);

        nxt_cnt  = cnt;
        nxt_tri  = tri_down;
        evt      = 1'b0;
        stop_req = 1'b0;
        rld_take = 1'b0;

        if (run) begin
            nxt_cnt = raw;
            nxt_tri = (ctrl.dir == DR_TRI) &&
                      (going_down ? (raw != CZERO) : (raw == CMAX));
            case (ctrl.mode)
                MD_ONE_TERM: begin
                    evt      = at_term;
                    stop_req = at_term;
                end
                MD_ONE_MATCH: begin
                    evt      = at_match;
                    stop_req = at_match;
                end
                MD_RLD_TERM: begin
                    evt      = at_term;
                    rld_take = at_term;
                end
                MD_RLD_MATCH: begin
                    evt      = at_match;
                    rld_take = at_match;
                end
                default: evt = at_match;
            endcase
            if (rld_take)
                nxt_cnt = reload_val;
        end
    end

endmodule

// File: rtl/updn_tmr_ptr.sv
module updn_tmr_ptr
    import updn_tmr_pkg::*;
#(
    parameter int NRLD = RLD_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic [$clog2(NRLD)-1:0] clr_idx,
    input  logic                    adv,
    input  logic [1:0]              step,
    output logic [$clog2(NRLD)-1:0] idx_q
);
    localparam int IW = $clog2(NRLD);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (clr)
            idx_q <= clr_idx;
        else if (adv)
            idx_q <= ptr_next(idx_q, step);
    end

    p_ptr_inc_r10: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && step == ST_INC) |=> idx_q == $past(idx_q) + IW'(1));

    p_ptr_dec_r10: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && step == ST_DEC) |=> idx_q == $past(idx_q) - IW'(1));

    p_ptr_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(idx_q));

endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              evt_o,
    output logic [TRIG_N-1:0] trig_o,
    output logic [RLD_IW-1:0] rld_idx_o,
    output logic [CNT_W-1:0]  ctrl_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    ctrl_t              ctrl;
    logic               clr_pulse;
    logic [RLD_IW-1:0]  clr_idx;
    logic [CNT_W-1:0]   match_q;
    logic [CNT_W-1:0]   reload_val;
    logic               run;
    logic [CNT_W-1:0]   nxt_cnt;
    logic               nxt_tri;
    logic               hit;
    logic               stop_req;
    logic               rld_take;
    logic               tri_q;

    assign run = tick_i && ctrl.en && ctrl.start;

    updn_tmr_regs #(.CNT_W(CNT_W), .NRLD(RLD_N)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .wr_addr    (wr_addr_i),
        .wr_data    (wr_data_i),
        .stop_req   (stop_req),
        .rd_idx     (rld_idx_o),
        .ctrl_q     (ctrl),
        .clr_pulse  (clr_pulse),
        .clr_idx    (clr_idx),
        .match_q    (match_q),
        .reload_val (reload_val)
    );

    updn_tmr_step #(.CNT_W(CNT_W)) step_i (
        .ctrl       (ctrl),
        .run        (run),
        .cnt        (count_o),
        .tri_down   (tri_q),
        .match      (match_q),
        .reload_val (reload_val),
        .nxt_cnt    (nxt_cnt),
        .nxt_tri    (nxt_tri),
        .evt        (hit),
        .stop_req   (stop_req),
        .rld_take   (rld_take)
    );

    updn_tmr_ptr #(.NRLD(RLD_N)) ptr_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_pulse),
        .clr_idx (clr_idx),
        .adv     (rld_take),
        .step    (ctrl.step),
        .idx_q   (rld_idx_o)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_pulse) begin
            count_o <= '0;
            tri_q   <= 1'b0;
            evt_o   <= 1'b0;
        end else begin
            count_o <= nxt_cnt;
            tri_q   <= nxt_tri;
            evt_o   <= hit;
        end
    end

    for (genvar t = 0; t < TRIG_N; t++) begin : g_trig
        always_ff @(posedge clk) begin
            if (rst || clr_pulse)
                trig_o[t] <= 1'b0;
            else
                trig_o[t] <= hit && (ctrl.trig == 2'(t + 1));
        end
    end

    assign ctrl_o = {{(CNT_W - CTRL_W){1'b0}}, ctrl};

    // R2: no qualified tick, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr_pulse) |=> $stable(count_o));

    // R3 / R4: a plain step moves by exactly one
    p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !rld_take && !clr_pulse) |=>
            (count_o == $past(count_o) + CNT_W'(1)) || (count_o == $past(count_o) - CNT_W'(1)));

    // R4: triangle turns at the top
    p_tri_top_r4: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl.dir == DR_TRI && count_o == CMAX && !rld_take && !clr_pulse) |=>
            count_o == CMAX - CNT_W'(1));

    // R11: clear forces zero and a quiet event
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> (count_o == '0) && !evt_o && (trig_o == '0));

    // R12: a trigger never fires without the event, and at most one fires
    p_trig_evt_r12: assert property (@(posedge clk) disable iff (rst)
        (trig_o != '0) |-> (evt_o && $onehot0(trig_o)));

endmodule

// File: tb/updn_timer_tb_top.sv
`timescale 1ns/100ps
module updn_timer_tb_top;

    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] count_o;
    logic        evt_o;
    logic [2:0]  trig_o;
    logic [1:0]  rld_idx_o;
    logic [31:0] ctrl_o;

    always #2.5 clk = ~clk;

    updn_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .count_o   (count_o),
        .evt_o     (evt_o),
        .trig_o    (trig_o),
        .rld_idx_o (rld_idx_o),
        .ctrl_o    (ctrl_o)
    );

    // reference model state
    logic [31:0] m_cnt, m_match;
    logic [31:0] m_rel [4];
    logic [13:0] m_ctrl;
    int          m_d;
    int          m_idx;
    logic        m_evt;
    logic [2:0]  m_trig;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input bit st, input bit clr,
                                       input logic [1:0] dir, input logic [2:0] mode,
                                       input logic [1:0] sel, input logic [1:0] stp,
                                       input logic [1:0] tsel);
        return {18'b0, tsel, stp, sel, mode, dir, clr, st, en};
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_match = '0; m_ctrl = '0; m_d = 1; m_idx = 0;
        m_evt = 0; m_trig = '0;
        for (int i = 0; i < 4; i++) m_rel[i] = '0;
    endtask

    task automatic model_update(input bit tk, input bit wr, input logic [2:0] a,
                                input logic [31:0] d);
        bit          ev, stop, term, mt, clr;
        logic [1:0]  dir, stp, tsel;
        logic [2:0]  mode;
        logic [31:0] nv;
        int          dlt;
        ev = 0; stop = 0;
        dir  = m_ctrl[4:3];
        mode = m_ctrl[7:5];
        stp  = m_ctrl[11:10];
        tsel = m_ctrl[13:12];
        clr  = wr && (a == 3'd0) && d[2];
        if (clr) begin
            m_cnt = '0; m_d = 1; m_idx = int'(d[9:8]);
        end else if (tk && m_ctrl[0] && m_ctrl[1]) begin
            if (dir == 2'd1) dlt = -1;
            else if (dir == 2'd2) begin
                dlt = m_d;
                if (m_cnt == MAXV) dlt = -1;
                if (m_cnt == 32'd0) dlt = 1;
            end else dlt = 1;
            nv = m_cnt + 32'(dlt);
            if (dir == 2'd2) begin
                if (nv == MAXV) m_d = -1;
                else if (nv == 32'd0) m_d = 1;
                else m_d = dlt;
            end else m_d = 1;
            if (dir == 2'd1) term = (nv == 32'd0);
            else if (dir == 2'd2) term = (nv == 32'd0) || (nv == MAXV);
            else term = (nv == MAXV);
            mt = (nv == m_match);
            case (mode)
                3'd1: begin ev = term; stop = term; end
                3'd2: begin ev = mt; stop = mt; end
                3'd3, 3'd4: begin
                    ev = (mode == 3'd3) ? term : mt;
                    if (ev) begin
                        nv = m_rel[m_idx];
                        if (stp == 2'd1) m_idx = (m_idx + 1) % 4;
                        if (stp == 2'd2) m_idx = (m_idx + 3) % 4;
                    end
                end
                default: ev = mt;
            endcase
            m_cnt = nv;
        end
        if (wr && a == 3'd0) m_ctrl = d[13:0] & ~14'h0004;
        else if (stop) m_ctrl[1] = 1'b0;
        if (wr && a == 3'd1) m_match = d;
        if (wr && a[2]) m_rel[a[1:0]] = d;
        m_evt  = ev;
        m_trig = (ev && tsel != 2'd0) ? (3'b001 << (tsel - 2'd1)) : 3'b000;
    endtask

    task automatic compare();
        chk(cur_req, "count", count_o, m_cnt);
        chk(cur_req, "evt", {31'b0, evt_o}, {31'b0, m_evt});
        chk(cur_req, "trig", {29'b0, trig_o}, {29'b0, m_trig});
        chk(cur_req, "idx", {30'b0, rld_idx_o}, 32'(m_idx));
        chk(cur_req, "ctrl", ctrl_o, {18'b0, m_ctrl});
    endtask

    task automatic cyc(input bit tk, input bit wr = 0, input logic [2:0] a = '0,
                       input logic [31:0] d = '0);
        tick_i = tk; wr_en_i = wr; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        model_update(tk, wr, a, d);
        @(negedge clk);
        tick_i = 0; wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0;
        compare();
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        cyc(0, 1, a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        cur_req = "R1";
        chk("R1", "count", count_o, 32'd0);
        chk("R1", "ctrl", ctrl_o, 32'd0);
        chk("R1", "outs", {27'b0, evt_o, trig_o, 1'b0}, 32'd0);
        chk("R1", "idx", {30'b0, rld_idx_o}, 32'd0);

        // R2 gating
        cur_req = "R2";
        wreg(3'd1, 32'd100);
        wreg(3'd0, cw(1, 0, 0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(2);
        wreg(3'd0, cw(0, 1, 0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(2);
        chk("R2", "held while disabled", count_o, 32'd0);
        wreg(3'd0, cw(1, 1, 0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        cyc(0); cyc(0);
        ticks(3);
        chk("R2", "counted ticks", count_o, 32'd3);

        // R3 wrap both ways
        cur_req = "R3";
        wreg(3'd0, cw(1, 1, 0, 2'd1, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(5);
        chk("R3", "down wrap", count_o, 32'hFFFF_FFFE);
        wreg(3'd0, cw(1, 1, 0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(3);
        chk("R3", "up wrap", count_o, 32'd1);

        // R4 triangle top
        cur_req = "R4";
        wreg(3'd0, cw(1, 1, 1, 2'd1, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(2);
        wreg(3'd0, cw(1, 1, 0, 2'd2, 3'd0, 2'd0, 2'd0, 2'd0));
        cyc(1);
        chk("R4", "reach top", count_o, MAXV);
        cyc(1);
        chk("R4", "turn at top", count_o, 32'hFFFF_FFFE);
        cyc(1);
        // R4 triangle bottom, entered through a reload
        wreg(3'd4, 32'd2);
        wreg(3'd0, cw(1, 1, 1, 2'd1, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(2);
        wreg(3'd0, cw(1, 1, 0, 2'd2, 3'd3, 2'd0, 2'd0, 2'd0));
        cyc(1);
        chk("R8", "terminal reload in triangle", count_o, 32'd2);
        wreg(3'd0, cw(1, 1, 0, 2'd2, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(2);
        chk("R4", "reach bottom", count_o, 32'd0);
        cyc(1);
        chk("R4", "turn at bottom", count_o, 32'd1);
        cyc(1);

        // R5 free run match event
        cur_req = "R5";
        wreg(3'd1, 32'd5);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(5);
        chk("R5", "evt at match", {31'b0, evt_o}, 32'd1);
        cyc(1);
        chk("R5", "evt one cycle", {31'b0, evt_o}, 32'd0);
        chk("R5", "keeps running", count_o, 32'd6);

        // R6 single shot at terminal, up then down
        cur_req = "R6";
        wreg(3'd0, cw(1, 1, 1, 2'd1, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(3);
        wreg(3'd0, cw(1, 1, 0, 2'd0, 3'd1, 2'd0, 2'd0, 2'd0));
        ticks(2);
        chk("R6", "stop at top", count_o, MAXV);
        chk("R6", "run bit cleared", {31'b0, ctrl_o[1]}, 32'd0);
        ticks(2);
        chk("R6", "holds after stop", count_o, MAXV);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(3);
        wreg(3'd0, cw(1, 1, 0, 2'd1, 3'd1, 2'd0, 2'd0, 2'd0));
        ticks(4);
        chk("R6", "stop at zero", count_o, 32'd0);

        // R7 single shot at match
        cur_req = "R7";
        wreg(3'd1, 32'd4);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd2, 2'd0, 2'd0, 2'd0));
        ticks(6);
        chk("R7", "stop at match", count_o, 32'd4);
        chk("R7", "run bit cleared", {31'b0, ctrl_o[1]}, 32'd0);

        // R8 + R10 terminal reload, pointer steps up and wraps
        cur_req = "R8";
        wreg(3'd4, 32'd4); wreg(3'd5, 32'd3); wreg(3'd6, 32'd2); wreg(3'd7, 32'd1);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd1, 2'd1, 2'd0));
        ticks(2);
        wreg(3'd0, cw(1, 1, 0, 2'd1, 3'd3, 2'd1, 2'd1, 2'd0));
        ticks(2);
        chk("R8", "reload entry 1", count_o, 32'd3);
        chk("R10", "step up", {30'b0, rld_idx_o}, 32'd2);
        ticks(5);
        chk("R10", "wrap 3 to 0", {30'b0, rld_idx_o}, 32'd0);
        cyc(1);
        chk("R8", "reload entry 0", count_o, 32'd4);

        // R9 + R10 match reload, pointer steps down and wraps
        cur_req = "R9";
        wreg(3'd4, 32'd1); wreg(3'd5, 32'd2); wreg(3'd6, 32'd0); wreg(3'd7, 32'd1);
        wreg(3'd1, 32'd3);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd4, 2'd0, 2'd2, 2'd0));
        ticks(3);
        chk("R9", "reload at match", count_o, 32'd1);
        chk("R10", "wrap 0 to 3", {30'b0, rld_idx_o}, 32'd3);
        ticks(4);
        chk("R9", "entry 2", count_o, 32'd0);
        chk("R10", "step down", {30'b0, rld_idx_o}, 32'd1);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd4, 2'd2, 2'd0, 2'd0));
        ticks(3);
        chk("R10", "keep", {30'b0, rld_idx_o}, 32'd2);

        // R11 clear
        cur_req = "R11";
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd3, 2'd0, 2'd0));
        chk("R11", "idx from select", {30'b0, rld_idx_o}, 32'd3);
        chk("R11", "clear bit reads 0", {31'b0, ctrl_o[2]}, 32'd0);
        ticks(2);
        cyc(1, 1, 3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        chk("R11", "clear beats tick", count_o, 32'd0);

        // R12 triggers
        cur_req = "R12";
        wreg(3'd1, 32'd2);
        for (int k = 0; k < 4; k++) begin
            wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd0, 2'd0, 2'(k)));
            ticks(2);
            chk("R12", "trig route", {29'b0, trig_o},
                (k == 0) ? 32'd0 : (32'd1 << (k - 1)));
            cyc(1);
        end

        // R13 unused addresses
        cur_req = "R13";
        wreg(3'd2, 32'd7);
        wreg(3'd3, 32'd7);
        wreg(3'd0, cw(1, 1, 1, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0));
        ticks(2);
        chk("R13", "match kept", {31'b0, evt_o}, 32'd1);

        // R10 mixed stress: triangle with match reload and irregular ticks
        cur_req = "R10";
        wreg(3'd4, 32'd0); wreg(3'd5, 32'd1); wreg(3'd6, 32'd2); wreg(3'd7, 32'd3);
        wreg(3'd1, 32'd5);
        wreg(3'd0, cw(1, 1, 1, 2'd2, 3'd4, 2'd0, 2'd1, 2'd2));
        begin
            logic [7:0] lf;
            lf = 8'hA5;
            for (int i = 0; i < 200; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                cyc(lf[0] | lf[2]);
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule